// File: doc/BRIEF.md
# Microcoded CPU Control Sequencer

This block is the control unit of a small 8-bit accumulator-style processor. A 4-bit micro-step counter walks through the steps of each instruction. A combinational decoder looks at the current step, the latched opcode and four status flags, and from them forms a 16-bit control word. That word drives the datapath strobes: bus output enables, register loads, memory-counter increment and select toggle, end of instruction, and halt. The word reaches the port with a fixed active-low polarity mask applied, so it can drive the datapath pins directly.

The low control bits are shared between two uses. When the load-constant strobe (bit 6) is asserted, bits 3:0 carry a 4-bit constant and bit 5 selects the ALU pass-through of the left source. The constant is either a register code (A=0, B=1, C=2, D=3, stack pointer low=4, I low=5, I high=6, J low=7, J high=8, T low=11, T high=12, U low=13) or an ALU operation code (add=0, subtract=1, and=2, or=3, xor=4, add-with-carry=5). When bit 6 is clear, bits 0 to 5 are individual strobes. The step counter takes the end-of-instruction and halt strobes only when bit 6 is clear. The output is a function of the current step and of the opcode and flag inputs in the same cycle. The step counter changes only at a clock edge.

Top module: `cseq_top`

## Requirements
- R1: While `rst_n` is low the step counter is 0 and the output is the fetch word, whatever the opcode and flags are.
- R2: At step 0 every opcode, listed or not, gives the fetch word: memory output enable (bit 15), load opcode (bit 1) and memory-counter increment (bit 0). That is logical 0x8003.
- R3: The port value is the logical word XOR 0xFF40, so bits 6 and 8 to 15 are active low.
- R4: If the end strobe (bit 2) is set with bit 6 clear, the counter is 0 after the next edge. If neither end nor halt is set this way, the counter advances by one each edge. Bit 2 inside a constant (bit 6 set) does not end the instruction.
- R5: If the halt strobe (bit 5) is set with bit 6 clear, the counter holds its value until reset.
- R6: A step after the last defined step of an instruction, and any step other than 0 of an unlisted opcode, gives the halt word (logical 0x0020).
- R7: No-op (0x00) gives zero words at steps 1 to 6 and the end strobe at step 7. Halt (0x01) gives the halt word at step 1 and the end strobe at step 2.
- R8: Load-immediate (0x10 to 0x13 for A to D, 0x14 for stack pointer low) gives two words. Step 1 is memory output enable, load left source, ALU-select, load constant, select toggle and the destination code. Step 2 is ALU output enable, load memory, select toggle, counter increment and end.
- R9: Move (0x20 | dst<<2 | src, with dst different from src, codes A to D). Step 1 is load constant and select toggle with the source code. Step 2 is memory output enable, load left source, ALU-select, load constant and the destination code. Step 3 is ALU output enable, load memory, select toggle and end.
- R10: ALU-with-immediate covers 0x40 add A, 0x41 and A, 0x42 or A, 0x43 xor A, 0x44 add-with-carry A and 0x45 add B, in five steps. Step 1 is memory output enable, load right source and counter increment. Step 2 is constant and toggle with the register. Step 3 is memory output enable, load left source, constant and the ALU code. Step 4 is ALU output enable, load left source, ALU-select and constant with the register. Step 5 is ALU output enable, load memory, toggle and end.
- R11: Compare-immediate (0x48 A, 0x49 B) follows steps 1 to 3 of R10 with the subtract code. Step 4 is ALU output enable, load left source, toggle and end. No load-memory strobe is ever set, so no register is written back.
- R12: Jump (0x50) has three steps. Step 1 is memory output enable, load left source and counter increment. Step 2 is memory output enable, load address high, ALU-select and load constant. Step 3 is ALU output enable, load address low and end.
- R13: Conditional jumps are 0x58 to 0x5F. Opcode bits 2:1 pick the flag input bit (0 zero, 1 carry, 2 overflow, 3 sign). Opcode bit 0 set means the jump is taken when that flag is clear. A taken jump follows R12. A jump that is not taken gives only the counter increment at steps 1 and 2 and only the end strobe at step 3.
- R14: No control word enables more than one of the four bus drivers (bits 12 to 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the step counter updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the step counter |
| opcode_i | input | 8 | Latched opcode from the datapath |
| flags_i | input | 4 | Status flags: [0] zero, [1] carry, [2] overflow, [3] sign |
| ctrl_n_o | output | 16 | Control word after the active-low mask |

## Verification
Two things happen at different times. A change on `opcode_i` or `flags_i` shows up on `ctrl_n_o` in the same cycle, with no register in the path. A strobe that moves the counter (advance, end or halt) takes effect only after the next rising edge. For that reason the bench drives inputs at the falling edge and samples 1 ns later, well before the next rising edge. For the full-table sweep it parks the counter on a chosen step and stops the clock. It then steps through every opcode and flag combination while no edge can occur. The directed runs let exactly one edge pass between checks, so each check sees the step that the previous word selected.

// File: rtl/cseq_pkg.sv
`timescale 1ns/1ps
package cseq_pkg;

   localparam int CW_W  = 16;
   localparam int KEY_W = 4;

   typedef logic [CW_W-1:0]  cword_t;
   typedef logic [KEY_W-1:0] key_t;

   // control word bit positions
   localparam int BI_MCINC = 0;
   localparam int BI_LDOP  = 1;
   localparam int BI_END   = 2;
   localparam int BI_LDRS  = 3;
   localparam int BI_LDIO  = 4;
   localparam int BI_HALT  = 5;
   localparam int BI_LDK   = 6;
   localparam int BI_TGSEL = 7;
   localparam int BI_LDMEM = 8;
   localparam int BI_LDLS  = 9;
   localparam int BI_LDAL  = 10;
   localparam int BI_LDAH  = 11;
   localparam int BI_OEAL  = 12;
   localparam int BI_OEAH  = 13;
   localparam int BI_OEALU = 14;
   localparam int BI_OEMEM = 15;

   localparam cword_t M_MCINC = cword_t'(1) << BI_MCINC;
   localparam cword_t M_LDOP  = cword_t'(1) << BI_LDOP;
   localparam cword_t M_END   = cword_t'(1) << BI_END;
   localparam cword_t M_LDRS  = cword_t'(1) << BI_LDRS;
   localparam cword_t M_HALT  = cword_t'(1) << BI_HALT;
   localparam cword_t M_ASEL  = M_HALT;   // same wire, meaning chosen by M_LDK
   localparam cword_t M_LDK   = cword_t'(1) << BI_LDK;
   localparam cword_t M_TGSEL = cword_t'(1) << BI_TGSEL;
   localparam cword_t M_LDMEM = cword_t'(1) << BI_LDMEM;
   localparam cword_t M_LDLS  = cword_t'(1) << BI_LDLS;
   localparam cword_t M_LDAL  = cword_t'(1) << BI_LDAL;
   localparam cword_t M_LDAH  = cword_t'(1) << BI_LDAH;
   localparam cword_t M_OEAL  = cword_t'(1) << BI_OEAL;
   localparam cword_t M_OEAH  = cword_t'(1) << BI_OEAH;
   localparam cword_t M_OEALU = cword_t'(1) << BI_OEALU;
   localparam cword_t M_OEMEM = cword_t'(1) << BI_OEMEM;

   localparam cword_t LOW_MASK = M_LDK | M_LDMEM | M_LDLS | M_LDAL | M_LDAH |
                                 M_OEAL | M_OEAH | M_OEALU | M_OEMEM;
   localparam cword_t W_FETCH  = M_OEMEM | M_LDOP | M_MCINC;
   localparam cword_t W_HALT   = M_HALT;

   // register codes carried in the constant field
   localparam key_t RK_A   = 4'd0;
   localparam key_t RK_B   = 4'd1;
   localparam key_t RK_SPL = 4'd4;

   // ALU operation codes carried in the constant field
   localparam key_t AK_ADD = 4'd0;
   localparam key_t AK_SUB = 4'd1;
   localparam key_t AK_AND = 4'd2;
   localparam key_t AK_OR  = 4'd3;
   localparam key_t AK_XOR = 4'd4;
   localparam key_t AK_ADC = 4'd5;

   // opcode points
   localparam logic [7:0] OP_NOP  = 8'h00;
   localparam logic [7:0] OP_HALT = 8'h01;
   localparam logic [7:0] OP_JMP  = 8'h50;

   typedef enum logic [3:0] {
      IC_NOP, IC_HALT, IC_LDI, IC_MOV, IC_ALUI, IC_CMP, IC_JMP, IC_JCC, IC_NONE
   } iclass_t;

   typedef struct packed {
      iclass_t    cls;
      key_t       dst;
      key_t       src;
      key_t       aop;
      logic [1:0] fsel;
      logic       fneg;
   } idec_t;

   function automatic cword_t kfield(input key_t k);
      return {{(CW_W-KEY_W){1'b0}}, k};
   endfunction

endpackage

// File: rtl/cseq_classify.sv
`timescale 1ns/1ps
module cseq_classify
   import cseq_pkg::*;
#(
   parameter int OP_W = 8
) (
   input  logic [OP_W-1:0] op_i,
   output idec_t           dec_o
);
   logic [7:0] op;
   assign op = op_i[7:0];

   always_comb begin
      dec_o     = '0;
      dec_o.cls = IC_NONE;
      if (op == OP_NOP) begin
         dec_o.cls = IC_NOP;
      end else if (op == OP_HALT) begin
         dec_o.cls = IC_HALT;
      end else if (op[7:3] == 5'b00010 && op[2:0] <= 3'd4) begin
         dec_o.cls = IC_LDI;
         dec_o.dst = (op[2:0] == 3'd4) ? RK_SPL : {2'b00, op[1:0]};
      end else if (op[7:4] == 4'h2 && op[3:2] != op[1:0]) begin
         dec_o.cls = IC_MOV;
         dec_o.dst = {2'b00, op[3:2]};
         dec_o.src = {2'b00, op[1:0]};
      end else if (op >= 8'h40 && op <= 8'h45) begin
         dec_o.cls = IC_ALUI;
         dec_o.dst = (op == 8'h45) ? RK_B : RK_A;
         case (op[2:0])
            3'd1:    dec_o.aop = AK_AND;
            3'd2:    dec_o.aop = AK_OR;
            3'd3:    dec_o.aop = AK_XOR;
            3'd4:    dec_o.aop = AK_ADC;
            default: dec_o.aop = AK_ADD;
         endcase
      end else if (op == 8'h48 || op == 8'h49) begin
         dec_o.cls = IC_CMP;
         dec_o.dst = {3'b000, op[0]};
         dec_o.aop = AK_SUB;
      end else if (op == OP_JMP) begin
         dec_o.cls = IC_JMP;
      end else if (op[7:3] == 5'b01011) begin
         dec_o.cls  = IC_JCC;
         dec_o.fsel = op[2:1];
         dec_o.fneg = op[0];
      end
   end
endmodule

// File: rtl/cseq_decode.sv
`timescale 1ns/1ps
module cseq_decode
   import cseq_pkg::*;
#(
   parameter int STEP_W = 4
) (
   input  idec_t             dec_i,
   input  logic              taken_i,
   input  logic [STEP_W-1:0] step_i,
   output cword_t            word_o
);
   logic [7:0] sn;

   always_comb begin
      sn     = 8'(step_i);
      word_o = W_HALT;
      if (sn == 8'd0) begin
         word_o = W_FETCH;
      end else begin
         case (dec_i.cls)
            IC_NOP: begin
               if (sn <= 8'd6)      word_o = '0;
               else if (sn == 8'd7) word_o = M_END;
            end
            IC_HALT: begin
               if (sn == 8'd2) word_o = M_END;
            end
            IC_LDI: begin
               if (sn == 8'd1)
                  word_o = M_OEMEM | M_LDLS | M_ASEL | M_LDK | M_TGSEL | kfield(dec_i.dst);
               else if (sn == 8'd2)
                  word_o = M_OEALU | M_LDMEM | M_TGSEL | M_MCINC | M_END;
            end
            IC_MOV: begin
               if (sn == 8'd1)
                  word_o = M_LDK | M_TGSEL | kfield(dec_i.src);
               else if (sn == 8'd2)
                  word_o = M_OEMEM | M_LDLS | M_ASEL | M_LDK | kfield(dec_i.dst);
               else if (sn == 8'd3)
                  word_o = M_OEALU | M_LDMEM | M_TGSEL | M_END;
            end
            IC_ALUI, IC_CMP: begin
               if (sn == 8'd1)
                  word_o = M_OEMEM | M_LDRS | M_MCINC;
               else if (sn == 8'd2)
                  word_o = M_LDK | M_TGSEL | kfield(dec_i.dst);
               else if (sn == 8'd3)
                  word_o = M_OEMEM | M_LDLS | M_LDK | kfield(dec_i.aop);
               else if (sn == 8'd4 && dec_i.cls == IC_CMP)
                  word_o = M_OEALU | M_LDLS | M_TGSEL | M_END;
               else if (sn == 8'd4)
                  word_o = M_OEALU | M_LDLS | M_ASEL | M_LDK | kfield(dec_i.dst);
               else if (sn == 8'd5 && dec_i.cls == IC_ALUI)
                  word_o = M_OEALU | M_LDMEM | M_TGSEL | M_END;
            end
            IC_JMP, IC_JCC: begin
               if (dec_i.cls == IC_JMP || taken_i) begin
                  if (sn == 8'd1)      word_o = M_OEMEM | M_LDLS | M_MCINC;
                  else if (sn == 8'd2) word_o = M_OEMEM | M_LDAH | M_ASEL | M_LDK;
                  else if (sn == 8'd3) word_o = M_OEALU | M_LDAL | M_END;
               end else begin
                  if (sn <= 8'd2)      word_o = M_MCINC;
                  else if (sn == 8'd3) word_o = M_END;
               end
            end
            default: word_o = W_HALT;
         endcase
      end
   end
endmodule

// File: rtl/cseq_stepper.sv
`timescale 1ns/1ps
module cseq_stepper #(
   parameter int STEP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              end_i,
   input  logic              hold_i,
   output logic [STEP_W-1:0] step_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      step_o <= '0;
      else if (hold_i) step_o <= step_o;
      else if (end_i)  step_o <= '0;
      else             step_o <= step_o + STEP_W'(1);
   end
endmodule

// File: rtl/cseq_drive.sv
`timescale 1ns/1ps
module cseq_drive
   import cseq_pkg::*;
#(
   parameter bit INVERT_EN = 1'b1
) (
   input  cword_t word_i,
   output cword_t pins_o
);
   generate
      if (INVERT_EN) begin : g_inv
         assign pins_o = word_i ^ LOW_MASK;
      end else begin : g_pass
         assign pins_o = word_i;
      end
   endgenerate
endmodule

// File: rtl/cseq_top.sv
`timescale 1ns/1ps
module cseq_top
   import cseq_pkg::*;
#(
   parameter int STEP_W    = 4,
   parameter int OP_W      = 8,
   parameter int FLAG_W    = 4,
   parameter bit INVERT_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [OP_W-1:0]         opcode_i,
   input  logic [FLAG_W-1:0]       flags_i,
   output logic [cseq_pkg::CW_W-1:0] ctrl_n_o
);
   localparam int FSEL_W = $clog2(FLAG_W);

   generate
      if (STEP_W < 4 || STEP_W > 8) begin : g_bad_step
         $error("cseq_top: STEP_W must be 4..8");
      end
      if (OP_W != 8) begin : g_bad_op
         $error("cseq_top: OP_W must be 8");
      end
      if (FLAG_W != 4) begin : g_bad_flag
         $error("cseq_top: FLAG_W must be 4");
      end
   endgenerate

   idec_t             dec;
   cword_t            word;
   logic [STEP_W-1:0] step;
   logic              taken;
   logic              end_s;
   logic              halt_s;

   cseq_classify #(.OP_W(OP_W)) u_cls (
      .op_i  (opcode_i),
      .dec_o (dec)
   );

   assign taken = flags_i[FSEL_W'(dec.fsel)] ^ dec.fneg;

   cseq_decode #(.STEP_W(STEP_W)) u_dec (
      .dec_i   (dec),
      .taken_i (taken),
      .step_i  (step),
      .word_o  (word)
   );

   // strobe meaning of bits 0..5 only when no constant is loaded
   assign end_s  = word[BI_END]  & ~word[BI_LDK];
   assign halt_s = word[BI_HALT] & ~word[BI_LDK];

   cseq_stepper #(.STEP_W(STEP_W)) u_stp (
      .clk    (clk),
      .rst_n  (rst_n),
      .end_i  (end_s),
      .hold_i (halt_s),
      .step_o (step)
   );

   cseq_drive #(.INVERT_EN(INVERT_EN)) u_drv (
      .word_i (word),
      .pins_o (ctrl_n_o)
   );

   p_fetch_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step == '0) |-> (word == W_FETCH));

   p_end_to_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (end_s && !halt_s) |=> (step == '0));

   p_halt_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      halt_s |=> $stable(step));

   p_one_driver_r14: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(word[BI_OEMEM:BI_OEAL]));

   p_no_wb_cmp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.cls == IC_CMP) |-> !word[BI_LDMEM]);
endmodule

// File: tb/cseq_top_bench.sv
`timescale 1ns/1ps
module cseq_top_bench;
   localparam logic [15:0] PMASK = 16'hFF40;
   localparam int NOPS = 39;
   localparam logic [7:0] OPS [NOPS] = '{
      8'h00, 8'h01, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14,
      8'h21, 8'h22, 8'h23, 8'h24, 8'h26, 8'h27, 8'h28, 8'h29, 8'h2B, 8'h2C, 8'h2D, 8'h2E,
      8'h40, 8'h41, 8'h42, 8'h43, 8'h44, 8'h45, 8'h48, 8'h49, 8'h50,
      8'h58, 8'h59, 8'h5A, 8'h5B, 8'h5C, 8'h5D, 8'h5E, 8'h5F,
      8'h20, 8'h46, 8'hFF };

   logic        clk = 1'b0;
   logic        clk_en = 1'b1;
   logic        rst_n = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [3:0]  flags = 4'h0;
   logic [15:0] ctrl_n;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2.5 if (clk_en) clk = ~clk;

   cseq_top u_cseq_top (
      .clk      (clk),
      .rst_n    (rst_n),
      .opcode_i (opcode),
      .flags_i  (flags),
      .ctrl_n_o (ctrl_n)
   );

   // expected logical word, written from the requirement text
   function automatic logic [15:0] model(input logic [7:0] op, input logic [3:0] fl, input int st);
      logic [15:0] k;
      logic        tk;
      if (st == 0) return 16'h8003;                                  // R2
      if (op == 8'h00) return (st < 7) ? 16'h0000 : (st == 7 ? 16'h0004 : 16'h0020); // R7
      if (op == 8'h01) return (st == 2) ? 16'h0004 : 16'h0020;       // R7
      if (op >= 8'h10 && op <= 8'h14) begin                          // R8
         k = (op == 8'h14) ? 16'd4 : {14'd0, op[1:0]};
         if (st == 1) return 16'h82E0 | k;
         if (st == 2) return 16'h4185;
         return 16'h0020;
      end
      if (op[7:4] == 4'h2 && op[3:2] != op[1:0]) begin               // R9
         if (st == 1) return 16'h00C0 | {14'd0, op[1:0]};
         if (st == 2) return 16'h8260 | {14'd0, op[3:2]};
         if (st == 3) return 16'h4184;
         return 16'h0020;
      end
      if (op >= 8'h40 && op <= 8'h45) begin                          // R10
         k = (op == 8'h45) ? 16'd1 : 16'd0;
         if (st == 1) return 16'h8009;
         if (st == 2) return 16'h00C0 | k;
         if (st == 3) return 16'h8240 | ((op == 8'h40 || op == 8'h45) ? 16'd0 :
                                         (op == 8'h41) ? 16'd2 : (op == 8'h42) ? 16'd3 :
                                         (op == 8'h43) ? 16'd4 : 16'd5);
         if (st == 4) return 16'h4260 | k;
         if (st == 5) return 16'h4184;
         return 16'h0020;
      end
      if (op == 8'h48 || op == 8'h49) begin                          // R11
         if (st == 1) return 16'h8009;
         if (st == 2) return 16'h00C0 | {15'd0, op[0]};
         if (st == 3) return 16'h8241;
         if (st == 4) return 16'h4284;
         return 16'h0020;
      end
      tk = (op == 8'h50) || (op[7:3] == 5'b01011 && (fl[op[2:1]] ^ op[0]));
      if (op == 8'h50 || op[7:3] == 5'b01011) begin                  // R12 R13
         if (tk) begin
            if (st == 1) return 16'h8201;
            if (st == 2) return 16'h8860;
            if (st == 3) return 16'h4404;
         end else begin
            if (st == 1 || st == 2) return 16'h0001;
            if (st == 3) return 16'h0004;
         end
         return 16'h0020;
      end
      return 16'h0020;                                               // R6
   endfunction

   function automatic string tag_of(input logic [7:0] op, input int st);
      if (st == 0) return "R2";
      if (op <= 8'h01) return "R7";
      if (op >= 8'h10 && op <= 8'h14) return "R8";
      if (op[7:4] == 4'h2 && op[3:2] != op[1:0]) return "R9";
      if (op >= 8'h40 && op <= 8'h45) return "R10";
      if (op == 8'h48 || op == 8'h49) return "R11";
      if (op == 8'h50) return "R12";
      if (op[7:3] == 5'b01011) return "R13";
      return "R6";
   endfunction

   task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s op=%02h fl=%h: got %04h expected %04h", tag, opcode, flags, got, exp);
      end
   endtask

   task automatic do_reset(input logic [7:0] op);
      clk_en = 1'b1;
      opcode = op;
      rst_n  = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic step_to(input int k);
      do_reset(8'h00);
      repeat (k) @(negedge clk);
   endtask

   // one edge then sample away from it
   task automatic tick;
      @(negedge clk);
      #1;
   endtask

   initial begin
      // R1: reset state with an arbitrary opcode applied
      rst_n  = 1'b0;
      opcode = 8'hA5;
      flags  = 4'hF;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      check(ctrl_n, 16'h8003 ^ PMASK, "R1");
      check(ctrl_n, 16'h7F43, "R3");

      // table walk: every step 0..7 of every opcode under all flags (R3 polarity on each)
      for (int k = 0; k < 8; k++) begin
         step_to(k);
         #1;
         clk_en = 1'b0;
         for (int i = 0; i < NOPS; i++) begin
            for (int f = 0; f < 16; f++) begin
               opcode = OPS[i];
               flags  = 4'(f);
               #1;
               check(ctrl_n, model(OPS[i], 4'(f), k) ^ PMASK, tag_of(OPS[i], k));
               check({15'd0, $countones(~ctrl_n[15:12]) <= 1}, 16'd1, "R14");
            end
         end
         opcode = 8'h00;
         clk_en = 1'b1;
      end

      // R4: load-immediate runs its steps and returns to fetch
      do_reset(8'h11); flags = 4'h0; #1;
      check(ctrl_n, 16'h8003 ^ PMASK, "R4");
      tick; check(ctrl_n, 16'h82E1 ^ PMASK, "R4");
      tick; check(ctrl_n, 16'h4185 ^ PMASK, "R4");
      tick; check(ctrl_n, 16'h8003 ^ PMASK, "R4");

      // R4 R8: bit 2 in the constant of load SP does not end the instruction
      do_reset(8'h14); #1;
      tick; check(ctrl_n, 16'h82E4 ^ PMASK, "R8");
      tick; check(ctrl_n, 16'h4185 ^ PMASK, "R4");

      // R5: halt holds the step
      step_to(1);
      opcode = 8'h01; #1;
      check(ctrl_n, 16'h0020 ^ PMASK, "R5");
      repeat (4) @(negedge clk);
      #1;
      check(ctrl_n, 16'h0020 ^ PMASK, "R5");
      opcode = 8'h50; #1;
      check(ctrl_n, 16'h8201 ^ PMASK, "R5");

      // R6: step past the end halts and stays
      step_to(4);
      opcode = 8'h10; #1;
      check(ctrl_n, 16'h0020 ^ PMASK, "R6");
      repeat (3) @(negedge clk);
      opcode = 8'h49; #1;
      check(ctrl_n, 16'h4284 ^ PMASK, "R6");

      // R13: not-taken jump on zero clear, then taken on zero set
      do_reset(8'h58); flags = 4'h0; #1;
      tick; check(ctrl_n, 16'h0001 ^ PMASK, "R13");
      tick; check(ctrl_n, 16'h0001 ^ PMASK, "R13");
      tick; check(ctrl_n, 16'h0004 ^ PMASK, "R13");
      tick; check(ctrl_n, 16'h8003 ^ PMASK, "R13");
      flags = 4'h1;
      tick; check(ctrl_n, 16'h8201 ^ PMASK, "R13");
      tick; check(ctrl_n, 16'h8860 ^ PMASK, "R13");
      tick; check(ctrl_n, 16'h4404 ^ PMASK, "R13");
      tick; check(ctrl_n, 16'h8003 ^ PMASK, "R13");

      // R7: no-op returns to fetch after step 7
      do_reset(8'h00);
      repeat (7) @(negedge clk);
      #1; check(ctrl_n, 16'h0004 ^ PMASK, "R7");
      tick; check(ctrl_n, 16'h8003 ^ PMASK, "R7");

      // R1: reset leaves a halted state
      step_to(1);
      opcode = 8'h01;
      repeat (2) @(negedge clk);
      rst_n = 1'b0; #1;
      check(ctrl_n, 16'h8003 ^ PMASK, "R1");
      rst_n = 1'b1;

      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            #(200000 * 5);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule